// File: doc/BRIEF.md
# Line Clamp and Preblank Pulse Generator

This block makes the per-line timing pulses for an image sensor's readout path. Each line, a pixel counter starts again on the horizontal sync strobe. Two pulse types are derived from that count: a clamp pulse and a preblank pulse. Each type has two independent channels. Every channel level starts a line at a programmed polarity. It inverts at each of two programmed pixel positions. Inside a programmed mask window, it is forced back to the starting polarity.

The toggle pairs are stored as a bank of patterns. A per-sequence table chooses the pattern, the starting polarity and the mask window for each pulse type. The sequence index is sampled with the horizontal sync strobe. Software loads the tables through a single-cycle write port. All writes go into shadow storage, which is copied into the working set only on a sync strobe. A line therefore always runs from one consistent set of settings.

A small state machine runs the line counter. Its states are:
- `LN_WAIT`: no sync strobe has been seen since reset.
- `LN_RUN`: the counter is advancing.
- `LN_HOLD`: the counter has saturated.

Its transitions are:
- `LN_WAIT` to `LN_RUN` on a sync strobe.
- `LN_RUN` to `LN_RUN` on a sync strobe, which restarts the line.
- `LN_RUN` to `LN_HOLD` when the count is at its top value and no strobe is present.
- `LN_HOLD` to `LN_RUN` on a sync strobe.
- Any unused encoding goes to `LN_WAIT`.

Top module: `lpg_top`

## Requirements
- R1: From reset until the first horizontal sync strobe, all four pulse outputs (`clamp_o[1:0]`, `blank_o[1:0]`) are 0. Output activity begins only after a strobe.
- R2: On the clock edge that samples `hsync` high, the pixel count becomes 0, so the first cycle after the strobe shows pixel 0. The count then rises by one per clock and saturates at 2^PW-1. While saturated, the count and all outputs hold steady until the next strobe.
- R3: Outside any mask, a channel at pixel n outputs `pol ^ (n >= A) ^ (n >= B)`. Here A and B are the channel's first and second toggle positions. The two channels of each type, and the two types, are independent.
- R4: When a channel's two toggle positions are equal, that channel stays at its starting polarity for the whole line.
- R5: The sequence index is sampled with the strobe. It selects, per pulse type, a polarity bit, a pattern number and a mask selector. A sequence index of NSEQ or more uses sequence 0. A pattern number of NPAT or more uses pattern 0.
- R6: A mask selector below NMASK names one of NMASK start/end pairs. For start <= n <= end (inclusive), the output equals the starting polarity. Toggles at positions inside the window still take effect after the window ends. A selector of NMASK or more disables masking.
- R7: Writes go to shadow storage and become visible only from the line that starts at the next strobe. A write in the strobe cycle itself is visible one line later.
- R8: The write address is `{type, kind[1:0], index[IDXW-1:0], sub[1:0]}`. `type` is 0 for clamp and 1 for preblank.
  - Kind 0 writes a toggle position. `index` is the pattern, `sub[1]` is the channel, and `sub[0]` selects first (0) or second (1).
  - Kind 1 writes a sequence entry. `index` is the sequence, with data `{maskselect, pattern, polarity}` packed from bit 0 upward. The polarity is 1 bit, the pattern is $clog2(NPAT) bits and the mask selector is $clog2(NMASK+1) bits.
  - Kind 2 writes a mask bound. `index` is the mask entry, and `sub[0]` selects start (0) or end (1).
  - Writes with an index beyond the table are dropped.
- R9: A strobe that arrives mid-line restarts the line at pixel 0 with fresh settings, whatever the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync strobe, one cycle per line |
| seq_idx | input | $clog2(NSEQ) | Vertical sequence index, sampled with `hsync` |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDXW+5 | Table write address (see R8) |
| wr_data | input | PW | Table write data |
| clamp_o | output | 2 | Clamp pulse, one bit per channel |
| blank_o | output | 2 | Preblank pulse, one bit per channel |

## Verification
A wrong toggle parity or a wrong count shows up as an output level that disagrees with the closed-form level of R3, in the very cycle of the faulty pixel. Since every cycle of every line is compared, the failure is seen at once. A fault in shadow-to-working copying or in sequence sampling shows only on the line after the strobe. For this reason the bench changes settings mid-line and compares the whole following line. Saturation faults appear as level or count movement once the count reaches its top value. The bench therefore runs each line past that point.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    // Number of pulse types (0 = clamp, 1 = preblank) and channels per type
    localparam int NUM_KINDS = 2;
    localparam int NUM_CH    = 2;

    typedef enum logic [1:0] {
        LN_WAIT = 2'd0,
        LN_RUN  = 2'd1,
        LN_HOLD = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        WK_TOGGLE = 2'd0,
        WK_SEQ    = 2'd1,
        WK_MASK   = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/lpg_line_fsm.sv
module lpg_line_fsm
    import lpg_pkg::*;
#(
    parameter int PW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync,
    output logic [PW-1:0] cnt,
    output logic          line_on,
    output logic          advance
);

    localparam logic [PW-1:0] CNT_MAX = {PW{1'b1}};

    line_state_e state_q, state_d;
    logic [PW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_WAIT;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_WAIT: if (hsync) state_d = LN_RUN;
            LN_RUN: begin
                if (hsync)                 state_d = LN_RUN;
                else if (cnt_q == CNT_MAX) state_d = LN_HOLD;
            end
            LN_HOLD: if (hsync) state_d = LN_RUN;
            default: state_d = LN_WAIT;
        endcase
    end

    // pixel counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     cnt_q <= '0;
        else if (hsync)                                 cnt_q <= '0;
        else if (state_q == LN_RUN && cnt_q != CNT_MAX) cnt_q <= cnt_q + PW'(1);
    end

    // outputs
    always_comb begin
        cnt     = cnt_q;
        line_on = (state_q != LN_WAIT);
        advance = (state_q == LN_RUN) && !hsync && (cnt_q != CNT_MAX);
    end

endmodule

// File: rtl/lpg_regs.sv
module lpg_regs
    import lpg_pkg::*;
#(
    parameter int PW    = 13,
    parameter int NSEQ  = 9,
    parameter int NPAT  = 10,
    parameter int NMASK = 3,
    parameter int SEQW  = 4,
    parameter int PATW  = 4,
    parameter int MSKW  = 2,
    parameter int MSELW = 2,
    parameter int IDXW  = 4,
    parameter int AW    = 9
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [AW-1:0]                          wr_addr,
    input  logic [PW-1:0]                          wr_data,
    input  logic                                   commit,
    input  logic [SEQW-1:0]                        seq_idx,
    output logic [NUM_KINDS-1:0][NUM_CH-1:0][PW-1:0] tog_a_o,
    output logic [NUM_KINDS-1:0][NUM_CH-1:0][PW-1:0] tog_b_o,
    output logic [NUM_KINDS-1:0]                   pol_o,
    output logic [NUM_KINDS-1:0]                   mask_en_o,
    output logic [NUM_KINDS-1:0][PW-1:0]           msk_lo_o,
    output logic [NUM_KINDS-1:0][PW-1:0]           msk_hi_o
);

    // shadow tables, written by the port
    logic [PW-1:0]    sh_tog  [NUM_KINDS][NPAT][NUM_CH][2];
    logic             sh_pol  [NUM_KINDS][NSEQ];
    logic [PATW-1:0]  sh_pat  [NUM_KINDS][NSEQ];
    logic [MSELW-1:0] sh_msel [NUM_KINDS][NSEQ];
    logic [PW-1:0]    sh_mlo  [NUM_KINDS][NMASK];
    logic [PW-1:0]    sh_mhi  [NUM_KINDS][NMASK];

    // working tables, copied on each sync strobe
    logic [PW-1:0]    ac_tog  [NUM_KINDS][NPAT][NUM_CH][2];
    logic             ac_pol  [NUM_KINDS][NSEQ];
    logic [PATW-1:0]  ac_pat  [NUM_KINDS][NSEQ];
    logic [MSELW-1:0] ac_msel [NUM_KINDS][NSEQ];
    logic [PW-1:0]    ac_mlo  [NUM_KINDS][NMASK];
    logic [PW-1:0]    ac_mhi  [NUM_KINDS][NMASK];
    logic [SEQW-1:0]  seq_q;

    logic             w_ty;
    wr_kind_e         w_kind;
    logic [IDXW-1:0]  w_idx;
    logic [1:0]       w_sub;

    always_comb begin
        w_ty   = wr_addr[AW-1];
        w_kind = wr_kind_e'(wr_addr[AW-2 -: 2]);
        w_idx  = wr_addr[2 +: IDXW];
        w_sub  = wr_addr[1:0];
    end

    // shadow write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                for (int p = 0; p < NPAT; p++)
                    for (int c = 0; c < NUM_CH; c++) begin
                        sh_tog[k][p][c][0] <= '0;
                        sh_tog[k][p][c][1] <= '0;
                    end
                for (int s = 0; s < NSEQ; s++) begin
                    sh_pol[k][s]  <= 1'b0;
                    sh_pat[k][s]  <= '0;
                    sh_msel[k][s] <= '1;
                end
                for (int m = 0; m < NMASK; m++) begin
                    sh_mlo[k][m] <= '0;
                    sh_mhi[k][m] <= '0;
                end
            end
        end else if (wr_en) begin
            case (w_kind)
                WK_TOGGLE: if (w_idx <= IDXW'(NPAT-1))
                    sh_tog[w_ty][w_idx[PATW-1:0]][w_sub[1]][w_sub[0]] <= wr_data;
                WK_SEQ: if (w_idx <= IDXW'(NSEQ-1)) begin
                    sh_pol[w_ty][w_idx[SEQW-1:0]]  <= wr_data[0];
                    sh_pat[w_ty][w_idx[SEQW-1:0]]  <= wr_data[PATW:1];
                    sh_msel[w_ty][w_idx[SEQW-1:0]] <= wr_data[PATW+MSELW:PATW+1];
                end
                WK_MASK: if (w_idx <= IDXW'(NMASK-1)) begin
                    if (w_sub[0]) sh_mhi[w_ty][w_idx[MSKW-1:0]] <= wr_data;
                    else          sh_mlo[w_ty][w_idx[MSKW-1:0]] <= wr_data;
                end
                default: ;
            endcase
        end
    end

    // working copy and sequence sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                for (int p = 0; p < NPAT; p++)
                    for (int c = 0; c < NUM_CH; c++) begin
                        ac_tog[k][p][c][0] <= '0;
                        ac_tog[k][p][c][1] <= '0;
                    end
                for (int s = 0; s < NSEQ; s++) begin
                    ac_pol[k][s]  <= 1'b0;
                    ac_pat[k][s]  <= '0;
                    ac_msel[k][s] <= '1;
                end
                for (int m = 0; m < NMASK; m++) begin
                    ac_mlo[k][m] <= '0;
                    ac_mhi[k][m] <= '0;
                end
            end
            seq_q <= '0;
        end else if (commit) begin
            ac_tog  <= sh_tog;
            ac_pol  <= sh_pol;
            ac_pat  <= sh_pat;
            ac_msel <= sh_msel;
            ac_mlo  <= sh_mlo;
            ac_mhi  <= sh_mhi;
            seq_q   <= (seq_idx <= SEQW'(NSEQ-1)) ? seq_idx : '0;
        end
    end

    // per-type selection for the running line
    logic [PATW-1:0]  pat_raw [NUM_KINDS];
    logic [PATW-1:0]  pat_use [NUM_KINDS];
    logic [MSELW-1:0] msel    [NUM_KINDS];

    always_comb begin
        for (int k = 0; k < NUM_KINDS; k++) begin
            pat_raw[k]   = ac_pat[k][seq_q];
            pat_use[k]   = (pat_raw[k] <= PATW'(NPAT-1)) ? pat_raw[k] : '0;
            msel[k]      = ac_msel[k][seq_q];
            pol_o[k]     = ac_pol[k][seq_q];
            mask_en_o[k] = (msel[k] <= MSELW'(NMASK-1));
            msk_lo_o[k]  = ac_mlo[k][msel[k][MSKW-1:0]];
            msk_hi_o[k]  = ac_mhi[k][msel[k][MSKW-1:0]];
            for (int c = 0; c < NUM_CH; c++) begin
                tog_a_o[k][c] = ac_tog[k][pat_use[k]][c][0];
                tog_b_o[k][c] = ac_tog[k][pat_use[k]][c][1];
            end
        end
    end

endmodule

// File: rtl/lpg_pulse.sv
module lpg_pulse #(
    parameter int PW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    input  logic          line_on,
    input  logic [PW-1:0] cnt,
    input  logic [PW-1:0] tog_a,
    input  logic [PW-1:0] tog_b,
    input  logic          pol,
    input  logic          mask_en,
    input  logic [PW-1:0] msk_lo,
    input  logic [PW-1:0] msk_hi,
    output logic          pulse
);

    logic par_q;
    logic hit;
    logic in_mask;

    // equal positions cancel, so the level is unchanged
    assign hit     = (cnt == tog_a) ^ (cnt == tog_b);
    assign in_mask = mask_en && (cnt >= msk_lo) && (cnt <= msk_hi);

    // parity of toggles already passed in this line, masked or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       par_q <= 1'b0;
        else if (restart) par_q <= 1'b0;
        else if (advance) par_q <= par_q ^ hit;
    end

    always_comb begin
        if (!line_on)     pulse = 1'b0;
        else if (in_mask) pulse = pol;
        else              pulse = pol ^ par_q ^ hit;
    end

endmodule

// File: rtl/lpg_top.sv
module lpg_top
    import lpg_pkg::*;
#(
    parameter int PW    = 13,
    parameter int NSEQ  = 9,
    parameter int NPAT  = 10,
    parameter int NMASK = 3,
    localparam int SEQW  = $clog2(NSEQ),
    localparam int PATW  = $clog2(NPAT),
    localparam int MSKW  = $clog2(NMASK),
    localparam int MSELW = $clog2(NMASK + 1),
    localparam int IDXW  = (PATW >= SEQW) ? ((PATW >= MSKW) ? PATW : MSKW)
                                          : ((SEQW >= MSKW) ? SEQW : MSKW),
    localparam int AW    = IDXW + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hsync,
    input  logic [SEQW-1:0] seq_idx,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [PW-1:0]   wr_data,
    output logic [1:0]      clamp_o,
    output logic [1:0]      blank_o
);

    logic [PW-1:0] cnt;
    logic          line_on;
    logic          advance;

    logic [NUM_KINDS-1:0][NUM_CH-1:0][PW-1:0] tog_a, tog_b;
    logic [NUM_KINDS-1:0]                     pol, mask_en;
    logic [NUM_KINDS-1:0][PW-1:0]             msk_lo, msk_hi;
    logic [NUM_KINDS-1:0][NUM_CH-1:0]         pulses;

    lpg_line_fsm #(.PW(PW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync   (hsync),
        .cnt     (cnt),
        .line_on (line_on),
        .advance (advance)
    );

    lpg_regs #(
        .PW(PW), .NSEQ(NSEQ), .NPAT(NPAT), .NMASK(NMASK), .SEQW(SEQW),
        .PATW(PATW), .MSKW(MSKW), .MSELW(MSELW), .IDXW(IDXW), .AW(AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .commit    (hsync),
        .seq_idx   (seq_idx),
        .tog_a_o   (tog_a),
        .tog_b_o   (tog_b),
        .pol_o     (pol),
        .mask_en_o (mask_en),
        .msk_lo_o  (msk_lo),
        .msk_hi_o  (msk_hi)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            lpg_pulse #(.PW(PW)) u_pulse (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (hsync),
                .advance (advance),
                .line_on (line_on),
                .cnt     (cnt),
                .tog_a   (tog_a[k][c]),
                .tog_b   (tog_b[k][c]),
                .pol     (pol[k]),
                .mask_en (mask_en[k]),
                .msk_lo  (msk_lo[k]),
                .msk_hi  (msk_hi[k]),
                .pulse   (pulses[k][c])
            );
        end
    end

    assign clamp_o = pulses[0];
    assign blank_o = pulses[1];

endmodule

// File: rtl/lpg_checks.sv
module lpg_checks #(
    parameter int PW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync,
    input logic          line_on,
    input logic [PW-1:0] cnt,
    input logic [1:0]    clamp_o,
    input logic [1:0]    blank_o
);

    localparam logic [PW-1:0] CNT_MAX = {PW{1'b1}};

    // R1: quiet outputs until a line has started
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !line_on |-> (clamp_o == 2'b00 && blank_o == 2'b00));

    // R1: line activity only begins from a strobe
    a_r1_start_by_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_on) |-> $past(hsync));

    // R2 / R9: strobe restarts the count at zero
    a_r2_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (cnt == '0 && line_on));

    // R2: count steps by one below the top value
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_on && !hsync && cnt != CNT_MAX) |=> (cnt == $past(cnt) + PW'(1)));

    // R2: saturated count and outputs stay put
    a_r2_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (line_on && !hsync && cnt == CNT_MAX) |=>
            (cnt == CNT_MAX && $stable(clamp_o) && $stable(blank_o)));

    // R2: once started the line machine never returns to waiting
    a_r2_stay_on: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(line_on));

endmodule

bind lpg_top lpg_checks #(.PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync   (hsync),
    .line_on (line_on),
    .cnt     (cnt),
    .clamp_o (clamp_o),
    .blank_o (blank_o)
);

// File: tb/tb_lpg_top.sv
`timescale 1ns/1ps
module tb_lpg_top;

    localparam int PW    = 7;
    localparam int NSEQ  = 9;
    localparam int NPAT  = 10;
    localparam int NMASK = 3;
    localparam int MAXC  = (1 << PW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic [3:0] seq_idx = '0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [6:0] wr_data = '0;
    logic [1:0] clamp_o, blank_o;

    lpg_top #(.PW(PW), .NSEQ(NSEQ), .NPAT(NPAT), .NMASK(NMASK)) dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .seq_idx(seq_idx),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clamp_o(clamp_o), .blank_o(blank_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // bench model: shadow and working copies
    int s_tog [2][NPAT][2][2];
    int s_pol [2][NSEQ];
    int s_pat [2][NSEQ];
    int s_msel[2][NSEQ];
    int s_mlo [2][NMASK];
    int s_mhi [2][NMASK];
    int a_tog [2][NPAT][2][2];
    int a_pol [2][NSEQ];
    int a_pat [2][NSEQ];
    int a_msel[2][NSEQ];
    int a_mlo [2][NMASK];
    int a_mhi [2][NMASK];
    int a_seq = 0;
    bit running = 0;
    int pix = 0;

    function automatic bit exp_bit(int k, int c, int n);
        int p, t1, t2, ms;
        bit lvl;
        p = a_pat[k][a_seq];
        if (p >= NPAT) p = 0;
        t1 = a_tog[k][p][c][0];
        t2 = a_tog[k][p][c][1];
        lvl = a_pol[k][a_seq][0] ^ (n >= t1) ^ (n >= t2);
        ms = a_msel[k][a_seq];
        if (ms < NMASK && n >= a_mlo[k][ms] && n <= a_mhi[k][ms])
            lvl = a_pol[k][a_seq][0];
        return lvl;
    endfunction

    task automatic check_now();
        logic [1:0] ec, eb;
        for (int c = 0; c < 2; c++) begin
            ec[c] = running ? exp_bit(0, c, pix) : 1'b0;
            eb[c] = running ? exp_bit(1, c, pix) : 1'b0;
        end
        n_chk += 2;
        if (clamp_o !== ec) begin
            n_fail++;
            $display("FAIL %s clamp pixel %0d: actual %b expected %b", cur_req, pix, clamp_o, ec);
        end
        if (blank_o !== eb) begin
            n_fail++;
            $display("FAIL %s blank pixel %0d: actual %b expected %b", cur_req, pix, blank_o, eb);
        end
    endtask

    task automatic step();
        check_now();
        @(negedge clk);
        if (running && pix < MAXC) pix++;
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    // R8 address map: {type, kind[1:0], index[3:0], sub[1:0]}
    task automatic wr(int ty, int kind, int idx, int sub, int data);
        wr_en   = 1'b1;
        wr_addr = {ty[0], kind[1:0], idx[3:0], sub[1:0]};
        wr_data = data[6:0];
        if (kind == 0 && idx < NPAT) s_tog[ty][idx][sub/2][sub%2] = data;
        if (kind == 1 && idx < NSEQ) begin
            s_pol[ty][idx]  = data & 1;
            s_pat[ty][idx]  = (data >> 1) & 15;
            s_msel[ty][idx] = (data >> 5) & 3;
        end
        if (kind == 2 && idx < NMASK) begin
            if (sub % 2 == 1) s_mhi[ty][idx] = data;
            else              s_mlo[ty][idx] = data;
        end
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_tog(int ty, int pat, int ch, int t1, int t2);
        wr(ty, 0, pat, ch * 2, t1);
        wr(ty, 0, pat, ch * 2 + 1, t2);
    endtask

    task automatic set_seq(int ty, int s, int pol, int pat, int msel);
        wr(ty, 1, s, 0, (msel << 5) | (pat << 1) | pol);
    endtask

    task automatic set_mask(int ty, int m, int lo, int hi);
        wr(ty, 2, m, 0, lo);
        wr(ty, 2, m, 1, hi);
    endtask

    task automatic strobe(int s);
        hsync   = 1'b1;
        seq_idx = s[3:0];
        step();
        hsync   = 1'b0;
        a_tog = s_tog; a_pol = s_pol; a_pat = s_pat; a_msel = s_msel;
        a_mlo = s_mlo; a_mhi = s_mhi;
        a_seq = (s < NSEQ) ? s : 0;
        running = 1;
        pix = 0;
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            for (int p = 0; p < NPAT; p++)
                for (int c = 0; c < 2; c++) begin
                    s_tog[k][p][c][0] = 0; s_tog[k][p][c][1] = 0;
                end
            for (int s = 0; s < NSEQ; s++) begin
                s_pol[k][s] = 0; s_pat[k][s] = 0; s_msel[k][s] = 3;
            end
            for (int m = 0; m < NMASK; m++) begin
                s_mlo[k][m] = 0; s_mhi[k][m] = 0;
            end
        end
        a_tog = s_tog; a_pol = s_pol; a_pat = s_pat; a_msel = s_msel;
        a_mlo = s_mlo; a_mhi = s_mhi;

        // R1: reset state and idle before first strobe
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check_now();
        rst_n = 1'b1;
        run(5);

        // R8: program tables through the write map (also idle, still R1)
        set_tog(0, 0, 0, 10, 40);
        set_tog(0, 0, 1, 20, 20);        // R4 equal pair
        set_tog(1, 0, 0, 30, 15);
        set_tog(1, 0, 1, 126, 50);
        set_seq(0, 0, 0, 0, 3);          // R6 selector 3 = no mask
        set_seq(1, 0, 1, 0, 3);
        run(3);

        // R3 R4 R8 R2: first line, run past saturation
        cur_req = "R3";
        strobe(0);
        run(MAXC + 15);

        // R2: saturated hold
        cur_req = "R2";
        run(20);

        // R5 R6: sequence 4 with masks and other patterns
        set_tog(0, 3, 0, 5, 100);
        set_tog(0, 3, 1, 0, MAXC);
        set_tog(1, 9, 0, 60, 70);
        set_tog(1, 9, 1, 2, 80);
        set_mask(0, 1, 90, 110);
        set_mask(1, 0, 0, 3);
        set_seq(0, 4, 1, 3, 1);
        set_seq(1, 4, 0, 9, 0);
        cur_req = "R6";
        strobe(4);
        run(MAXC + 5);

        // R5: pattern number out of range, sequence index out of range
        set_seq(0, 7, 1, 12, 3);
        set_seq(1, 7, 0, 15, 3);
        cur_req = "R5";
        strobe(7);
        run(MAXC + 3);
        strobe(11);
        run(MAXC + 3);

        // R7: mid-line write shows only on the next line
        cur_req = "R7";
        strobe(0);
        run(20);
        set_tog(0, 0, 0, 50, 60);
        set_seq(1, 0, 0, 9, 3);
        run(MAXC);
        strobe(0);
        run(MAXC + 2);

        // R9: early strobe restarts the line
        cur_req = "R9";
        strobe(4);
        run(30);
        strobe(0);
        run(60);
        strobe(4);
        run(MAXC + 2);

        // R3: sweep toggle pairs on one channel of each type
        cur_req = "R3";
        for (int a = 0; a <= MAXC; a += 9) begin
            for (int b = 0; b <= MAXC; b += 13) begin
                set_tog(0, 0, 0, a, b);
                set_tog(1, 0, 1, b, a);
                strobe(0);
                run(MAXC + 2);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule